// File: doc/BRIEF.md
# Transmit-Context Interrupt Event Register

This block records completion interrupts from eight isochronous transmit contexts, one sticky event bit per context. Bit i latches on the rising edge of context i's completion strobe. That strobe pulses when a context finishes its last output command with interrupt requests enabled. Software can also force bits on through a set address and remove them through a separate clear address. A clear only happens when a 1 is written to the bit's position.

A companion enable mask decides which latched events count toward one summary request line. That line feeds the transmit-interrupt position (bit 6) of a top-level interrupt event register, which lies outside this block. Software sees the summary bit, reads the masked view to find which contexts need service, and then clears those events.

All register accesses are single-cycle. A write is taken on the clock edge where `bus_wr_i` is high. Read data is combinational while `bus_rd_i` is high and is zero otherwise.

Top module: `txint_event_regs`

## Requirements
- R1: After reset the event bits, the mask bits and `summary_irq_o` are all 0. Event bit i (bits 7..0) belongs to context i.
- R2: Data bits 31..8 always read as 0, and writing them has no effect on any state.
- R3: A 0-to-1 transition of `ctx_irq_i[i]` sets event bit i at the next clock edge. A level held high does not set the bit again after it has been cleared.
- R4: Writing to address 0x90 sets every event bit whose data bit is 1. Data bits that are 0 leave their event bits unchanged.
- R5: An event bit falls only when it is cleared by a write to address 0x94 with a 1 in its position. Zero data bits there have no effect.
- R6: A read at address 0x94 returns the event bits ANDed with the mask bits.
- R7: A read at address 0x90 returns the raw, unmasked event bits.
- R8: Writing ones to 0x98 sets mask bits. Writing ones to 0x9C clears mask bits. A read at either address returns the mask.
- R9: If a rising input edge and a clear write hit the same event bit in one cycle, the bit ends up set.
- R10: `summary_irq_o` is registered. It equals the OR of (event AND mask) as it stood one clock earlier.
- R11: Reads at any other address return 0, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_irq_i | input | 8 | Per-context completion interrupt strobes |
| bus_wr_i | input | 1 | Write strobe, one cycle |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, zero when not reading |
| summary_irq_o | output | 1 | Masked-event summary request |

## Verification
The bench targets four cases that a flawed design would get wrong:
- **Edge versus level.** The bench holds an input high across a clear. A design that is level-sensitive would set the event again at once.
- **Edge versus clear in one cycle.** The bench lands a fresh input edge and a clear write on the same bit in the same cycle. A design that lets the clear win would silently lose that event.
- **Zero bits and reserved bits.** The bench writes zeros, and writes only to bits 31..8. A design that treated a write as a load instead of a per-bit set or clear would wipe state that should have stayed.
- **Address and timing mix-ups.** The bench reads the raw view and the masked view back to back, and compares the summary line one cycle after each change. A design that swapped the two views, or left the summary unregistered, would be off by a view or by a cycle.

// File: rtl/txint_pkg.sv
package txint_pkg;
  localparam logic [7:0] OFS_EV_SET = 8'h90;
  localparam logic [7:0] OFS_EV_CLR = 8'h94;
  localparam logic [7:0] OFS_MK_SET = 8'h98;
  localparam logic [7:0] OFS_MK_CLR = 8'h9C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_EV_SET,
    SEL_EV_CLR,
    SEL_MK_SET,
    SEL_MK_CLR
  } reg_sel_e;

  // Decode an 8-bit offset into a register selector.
  function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
    case (ofs)
      OFS_EV_SET: decode_ofs = SEL_EV_SET;
      OFS_EV_CLR: decode_ofs = SEL_EV_CLR;
      OFS_MK_SET: decode_ofs = SEL_MK_SET;
      OFS_MK_CLR: decode_ofs = SEL_MK_CLR;
      default:    decode_ofs = SEL_NONE;
    endcase
  endfunction

  // Next state of a sticky bit vector: hardware edges beat software clears.
  function automatic logic [31:0] sticky_next(input logic [31:0] cur,
                                              input logic [31:0] hw,
                                              input logic [31:0] sw_set,
                                              input logic [31:0] sw_clr);
    sticky_next = (cur | hw | sw_set) & ~(sw_clr & ~hw);
  endfunction
endpackage

// File: rtl/txint_edge_det.sv
module txint_edge_det #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= lvl_i[i];
    end
    assign rise_o[i] = lvl_i[i] & ~prev_q[i];
  end
endmodule

// File: rtl/txint_w1sc_reg.sv
module txint_w1sc_reg
  import txint_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hw_set_i,
  input  logic [W-1:0] sw_set_i,
  input  logic [W-1:0] sw_clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] nxt;
  logic [31:0]  nxt_wide;

  assign nxt_wide = sticky_next(32'(q_o), 32'(hw_set_i), 32'(sw_set_i), 32'(sw_clr_i));
  assign nxt      = nxt_wide[W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= nxt;
  end
endmodule

// File: rtl/txint_bus_dec.sv
module txint_bus_dec
  import txint_pkg::*;
#(
  parameter int W      = 8,
  parameter int DATA_W = 32
) (
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      ev_i,
  input  logic [W-1:0]      mask_i,
  output logic [W-1:0]      ev_set_o,
  output logic [W-1:0]      ev_clr_o,
  output logic [W-1:0]      mk_set_o,
  output logic [W-1:0]      mk_clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  reg_sel_e sel;
  logic [W-1:0] rd_val;

  assign sel = decode_ofs(addr_i);

  assign ev_set_o = (wr_i && sel == SEL_EV_SET) ? wdata_i : '0;
  assign ev_clr_o = (wr_i && sel == SEL_EV_CLR) ? wdata_i : '0;
  assign mk_set_o = (wr_i && sel == SEL_MK_SET) ? wdata_i : '0;
  assign mk_clr_o = (wr_i && sel == SEL_MK_CLR) ? wdata_i : '0;

  always_comb begin
    case (sel)
      SEL_EV_SET:             rd_val = ev_i;
      SEL_EV_CLR:             rd_val = ev_i & mask_i;
      SEL_MK_SET, SEL_MK_CLR: rd_val = mask_i;
      default:                rd_val = '0;
    endcase
  end

  assign rdata_o = rd_i ? DATA_W'(rd_val) : '0;
endmodule

// File: rtl/txint_summary.sv
module txint_summary #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  logic any_pending;
  assign any_pending = |(ev_i & mask_i);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= any_pending;
  end
endmodule

// File: rtl/txint_event_regs.sv
module txint_event_regs #(
  parameter int NUM_CTX = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CTX-1:0] ctx_irq_i,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [7:0]         bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic               summary_irq_o
);
  // Named internal events, visible to the bound checker.
  logic [NUM_CTX-1:0] ctx_rise;
  logic [NUM_CTX-1:0] ev_q;
  logic [NUM_CTX-1:0] mask_q;
  logic [NUM_CTX-1:0] ev_set_w;
  logic [NUM_CTX-1:0] ev_clr_w;
  logic [NUM_CTX-1:0] mk_set_w;
  logic [NUM_CTX-1:0] mk_clr_w;

  txint_edge_det #(.W(NUM_CTX)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (ctx_irq_i),
    .rise_o (ctx_rise)
  );

  txint_bus_dec #(.W(NUM_CTX), .DATA_W(DATA_W)) u_dec (
    .wr_i     (bus_wr_i),
    .rd_i     (bus_rd_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i[NUM_CTX-1:0]),
    .ev_i     (ev_q),
    .mask_i   (mask_q),
    .ev_set_o (ev_set_w),
    .ev_clr_o (ev_clr_w),
    .mk_set_o (mk_set_w),
    .mk_clr_o (mk_clr_w),
    .rdata_o  (bus_rdata_o)
  );

  txint_w1sc_reg #(.W(NUM_CTX)) u_event (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_set_i (ctx_rise),
    .sw_set_i (ev_set_w),
    .sw_clr_i (ev_clr_w),
    .q_o      (ev_q)
  );

  txint_w1sc_reg #(.W(NUM_CTX)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_set_i ('0),
    .sw_set_i (mk_set_w),
    .sw_clr_i (mk_clr_w),
    .q_o      (mask_q)
  );

  txint_summary #(.W(NUM_CTX)) u_sum (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_i   (ev_q),
    .mask_i (mask_q),
    .irq_o  (summary_irq_o)
  );
endmodule

// File: rtl/txint_event_chk.sv
module txint_event_chk #(
  parameter int NUM_CTX = 8,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_rd_i,
  input logic [7:0]         bus_addr_i,
  input logic [DATA_W-1:0]  bus_rdata_o,
  input logic               summary_irq_o,
  input logic [NUM_CTX-1:0] ctx_rise,
  input logic [NUM_CTX-1:0] ev_q,
  input logic [NUM_CTX-1:0] mask_q,
  input logic [NUM_CTX-1:0] ev_clr_w,
  input logic [NUM_CTX-1:0] mk_set_w
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata_o[DATA_W-1:NUM_CTX] == '0);

  // R3 R9
  edge_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ctx_rise) |=> ((ev_q & $past(ctx_rise)) == $past(ctx_rise)));

  // R5
  clear_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(ev_q) & ~ev_q) & ~$past(ev_clr_w)) == '0));

  // R6
  masked_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && bus_addr_i == 8'h94) |-> (bus_rdata_o == DATA_W'(ev_q & mask_q)));

  // R8
  mask_rise_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((mask_q & ~$past(mask_q)) & ~$past(mk_set_w)) == '0));

  // R10
  summary_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (summary_irq_o == (|($past(ev_q) & $past(mask_q)))));
endmodule

bind txint_event_regs txint_event_chk #(.NUM_CTX(NUM_CTX), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_rd_i      (bus_rd_i),
  .bus_addr_i    (bus_addr_i),
  .bus_rdata_o   (bus_rdata_o),
  .summary_irq_o (summary_irq_o),
  .ctx_rise      (ctx_rise),
  .ev_q          (ev_q),
  .mask_q        (mask_q),
  .ev_clr_w      (ev_clr_w),
  .mk_set_w      (mk_set_w)
);

// File: tb/tb_txint_event_regs.sv
module tb_txint_event_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ctx_irq = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sum;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // Reference state kept by the bench.
  logic [7:0] m_ev = '0, m_mask = '0, m_prev = '0;
  logic       m_sum = 1'b0;

  always #5 clk = ~clk;

  txint_event_regs dut (
    .clk(clk), .rst_n(rst_n), .ctx_irq_i(ctx_irq), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .summary_irq_o(sum)
  );

  function automatic logic [31:0] expect_read(input logic [7:0] a);
    if (a == 8'h90) return {24'h0, m_ev};
    if (a == 8'h94) return {24'h0, m_ev & m_mask};
    if (a == 8'h98 || a == 8'h9C) return {24'h0, m_mask};
    return 32'h0;
  endfunction

  function automatic string read_req(input logic [7:0] a);
    if (a == 8'h90) return "R7";
    if (a == 8'h94) return "R6";
    if (a == 8'h98 || a == 8'h9C) return "R8";
    return "R11";
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One bus cycle: drive after falling edge, check before rising edge,
  // then advance the reference state.
  task automatic step(input logic [7:0] irq, input bit w, input bit r,
                      input logic [7:0] a, input logic [31:0] d, input string tag);
    logic [7:0] rise, es, ec, ms, mc;
    logic [31:0] ex;
    @(negedge clk);
    ctx_irq = irq; wr = w; rd = r; addr = a; wdata = d;
    #2;
    if (r) begin
      ex = expect_read(a);
      check(rdata == ex, {tag, " ", read_req(a)}, rdata, ex);
      check(rdata[31:8] == 24'h0, {tag, " R2"}, rdata, ex);
    end
    check(sum == m_sum, {tag, " R10"}, {31'h0, sum}, {31'h0, m_sum});
    @(posedge clk);
    rise = irq & ~m_prev;
    m_prev = irq;
    es = (w && a == 8'h90) ? d[7:0] : 8'h0;
    ec = (w && a == 8'h94) ? d[7:0] : 8'h0;
    ms = (w && a == 8'h98) ? d[7:0] : 8'h0;
    mc = (w && a == 8'h9C) ? d[7:0] : 8'h0;
    m_sum = (m_ev & m_mask) != 8'h0;
    for (int i = 0; i < 8; i++) begin
      if (rise[i] || es[i]) m_ev[i] = 1'b1;
      else if (ec[i])       m_ev[i] = 1'b0;
      if (ms[i])            m_mask[i] = 1'b1;
      else if (mc[i])       m_mask[i] = 1'b0;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] cur_irq;
    void'($urandom(32'h5EED_0421));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    step(8'h00, 0, 1, 8'h90, 0, "R1");
    step(8'h00, 0, 1, 8'h94, 0, "R1");
    step(8'h00, 0, 1, 8'h98, 0, "R1");
    // R4 set writes, zeros keep bits
    step(8'h00, 1, 0, 8'h90, 32'hA5, "R4");
    step(8'h00, 0, 1, 8'h90, 0, "R4");
    step(8'h00, 1, 0, 8'h90, 32'h0, "R4");
    step(8'h00, 0, 1, 8'h90, 0, "R4");
    // R5 clear writes
    step(8'h00, 1, 0, 8'h94, 32'h0, "R5");
    step(8'h00, 0, 1, 8'h90, 0, "R5");
    step(8'h00, 1, 0, 8'h94, 32'h05, "R5");
    step(8'h00, 0, 1, 8'h90, 0, "R5");
    // R2 reserved bits only
    step(8'h00, 1, 0, 8'h90, 32'hFFFF_FF00, "R2");
    step(8'h00, 1, 0, 8'h94, 32'hFFFF_FF00, "R2");
    step(8'h00, 0, 1, 8'h90, 0, "R2");
    // R8 mask, R6 masked view, R10 summary
    step(8'h00, 1, 0, 8'h98, 32'h30, "R8");
    step(8'h00, 0, 1, 8'h94, 0, "R6");
    step(8'h00, 1, 0, 8'h98, 32'h80, "R8");
    step(8'h00, 0, 1, 8'h9C, 0, "R8");
    step(8'h00, 0, 1, 8'h94, 0, "R10");
    step(8'h00, 1, 0, 8'h9C, 32'hFF, "R8");
    step(8'h00, 0, 1, 8'h98, 0, "R10");
    step(8'h00, 1, 0, 8'h94, 32'hFF, "R5");
    // R3 edge sets, held level does not re-set after clear
    step(8'h01, 0, 0, 8'h00, 0, "R3");
    step(8'h01, 0, 1, 8'h90, 0, "R3");
    step(8'h01, 1, 0, 8'h94, 32'h01, "R3");
    step(8'h01, 0, 1, 8'h90, 0, "R3");
    step(8'h01, 0, 1, 8'h90, 0, "R3");
    // R9 edge and clear in the same cycle
    step(8'h03, 1, 0, 8'h94, 32'h02, "R9");
    step(8'h03, 0, 1, 8'h90, 0, "R9");
    // R11 unmapped address
    step(8'h00, 1, 0, 8'h40, 32'hFF, "R11");
    step(8'h00, 1, 1, 8'h40, 32'hFF, "R11");
    step(8'h00, 0, 1, 8'h90, 0, "R11");
    step(8'h00, 0, 1, 8'h98, 0, "R11");

    // Constrained random mix
    cur_irq = 8'h00;
    for (int k = 0; k < 4000; k++) begin
      logic [7:0] a;
      logic [31:0] d;
      int pick;
      if ($urandom_range(0, 3) == 0) cur_irq = 8'($urandom());
      pick = $urandom_range(0, 9);
      case (pick)
        0, 1: a = 8'h90;
        2, 3, 4: a = 8'h94;
        5: a = 8'h98;
        6: a = 8'h9C;
        7: a = 8'($urandom());
        default: a = 8'h94;
      endcase
      d = $urandom();
      if ($urandom_range(0, 2) == 0) d = d & 32'h0000_0011;
      step(cur_irq, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, a, d, "RND");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule